// File: doc/BRIEF.md
# Page Write Buffer with Write Protection

The block sits behind the front end of a two-wire serial memory bus. It gathers the data bytes of one write sequence into a page buffer of 32 bytes. It copies them into the storage array only when the sequence ends with a clean stop. The front end opens a sequence with a start pulse that carries the 13-bit target address. It then delivers one strobe per received data byte, and finally a stop pulse. With that pulse it reports whether the stop cut a byte short.

After a valid stop, the block runs a self-timed program cycle whose length, counted in clock cycles, is a parameter. During that cycle it raises `busy`, so that the front end stops answering its address. Meanwhile the block walks the page and issues one array write per buffered byte. A write-protect pin locks the top quarter of the address space: a write aimed there while the pin is high is still accepted on the bus, but the commit is dropped and no program cycle runs.

Top module: `pgwr_commit`

## Requirements
- R1: After synchronous reset, `busy` and `mem_we` are low, and no sequence is open.
- R2: The first data byte lands at page offset `addr_in[4:0]`, and each later byte at the next offset. On commit, each byte is written to array address `{addr_in[12:5], offset}` with the data received for that offset.
- R3: A stop that commits raises `busy` in the cycle after the stop pulse. `busy` then stays high for exactly `PROG_CYCLES` consecutive cycles.
- R4: When more than 32 bytes arrive, the offset wraps from 31 to 0 within the same page, and a later byte replaces the earlier one at that offset. Address bits 12..5 never change within one sequence.
- R5: During the program cycle, only offsets that received data are written, each exactly once, one per cycle, in ascending offset order. The other bytes of the page see no write.
- R6: A stop with no preceding data byte, or a stop with `stop_mid_byte` high, commits nothing. `busy` stays low and no array write occurs.
- R7: If `wp_pin` is high at the stop and `addr_in[12:11]` is 2'b11 (addresses 0x1800 to 0x1FFF), the block commits nothing and `busy` stays low. The same write commits normally with `wp_pin` low, or when it is aimed below 0x1800.
- R8: While `busy` is high, `seq_start`, `byte_vld` and `stop_evt` are ignored. The cycle in progress keeps its length and writes, and no sequence is left open afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_start | input | 1 | Opens a write sequence at `addr_in` |
| addr_in | input | 13 | Start address of the sequence |
| byte_vld | input | 1 | One received data byte is on `byte_data` |
| byte_data | input | 8 | Data byte |
| stop_evt | input | 1 | Stop condition ends the sequence |
| stop_mid_byte | input | 1 | The stop came while a byte was incomplete |
| wp_pin | input | 1 | Write-protect pin level |
| busy | output | 1 | Program cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
A corrupt valid mask or offset pointer shows up during the program cycle that follows. There, `mem_we` pulses at the wrong addresses, with the wrong data, or a wrong number of times, and the scoreboard sees each such pulse in the cycle it occurs. A wrong decision at the stop shows one cycle after the stop pulse, as a `busy` level that disagrees with the protection, empty-sequence or partial-byte rule. A timer fault shows as a `busy` run whose length differs from `PROG_CYCLES` by the end of the cycle.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_FILL = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic open;
        logic wr;
        logic commit;
    } seq_ctl_t;

    // Top quarter of the array: both address msbs set.
    function automatic logic top_quarter(input logic [1:0] msbs);
        return msbs == 2'b11;
    endfunction

endpackage

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [OFS_W-1:0]  rd_idx_i,
    output logic [(1<<OFS_W)-1:0] mask_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int NB = 1 << OFS_W;

    logic [DATA_W-1:0] store_q [NB];
    logic [NB-1:0]     mask_q;
    logic [OFS_W-1:0]  ofs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ofs_q  <= '0;
        end else if (open_i) begin
            mask_q <= '0;
            ofs_q  <= ofs_i;
        end else if (wr_i) begin
            mask_q[ofs_q] <= 1'b1;
            ofs_q         <= ofs_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_i && !open_i) begin
            store_q[ofs_q] <= data_i;
        end
    end

    assign mask_o    = mask_q;
    assign rd_data_o = store_q[rd_idx_i];

    AST_MASK_GROWS: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !open_i) |=> mask_q[$past(ofs_q)]) else $error("mask bit not set"); // R2

endmodule

// File: rtl/pgwr_prog_timer.sv
module pgwr_prog_timer #(
    parameter int CYCLES = 200000,
    parameter int CW     = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    output logic          run_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic          run_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (run_q) begin
            if (cnt_q == LAST) begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end
    end

    assign run_o = run_q;
    assign cnt_o = cnt_q;

    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_q != LAST) |=> run_q) else $error("cycle ended early"); // R3
    AST_TIMER_START: assert property (@(posedge clk) disable iff (rst)
        (start_i && !run_q) |=> (run_q && cnt_q == '0)) else $error("cycle not started"); // R3

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
    import pgwr_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int OFS_W       = 5,
    parameter int PROG_CYCLES = 200000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_evt,
    input  logic              stop_mid_byte,
    input  logic              wp_pin,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int NB     = 1 << OFS_W;
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int CLG    = $clog2(PROG_CYCLES);
    localparam int CW     = (CLG > OFS_W) ? CLG : OFS_W + 1;

    seq_state_e        state_q;
    logic [PAGE_W-1:0] page_q;
    seq_ctl_t          ctl;
    logic [NB-1:0]     mask;
    logic [DATA_W-1:0] rd_data;
    logic [CW-1:0]     cnt;
    logic [OFS_W-1:0]  idx;
    logic              locked;
    logic              stop_here;

    assign idx       = cnt[OFS_W-1:0];
    assign locked    = wp_pin && top_quarter(page_q[PAGE_W-1 -: 2]);
    assign stop_here = (state_q == SEQ_FILL) && stop_evt && !busy && !seq_start;

    always_comb begin
        ctl        = '0;
        ctl.open   = seq_start && !busy;
        ctl.wr     = byte_vld && (state_q == SEQ_FILL) && !busy && !seq_start;
        ctl.commit = stop_here && (|mask) && !stop_mid_byte && !locked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            page_q  <= '0;
        end else if (ctl.open) begin
            state_q <= SEQ_FILL;
            page_q  <= addr_in[ADDR_W-1:OFS_W];
        end else if (stop_here) begin
            state_q <= SEQ_IDLE;
        end
    end

    pgwr_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .open_i   (ctl.open),
        .ofs_i    (addr_in[OFS_W-1:0]),
        .wr_i     (ctl.wr),
        .data_i   (byte_data),
        .rd_idx_i (idx),
        .mask_o   (mask),
        .rd_data_o(rd_data)
    );

    pgwr_prog_timer #(.CYCLES(PROG_CYCLES), .CW(CW)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .start_i(ctl.commit),
        .run_o  (busy),
        .cnt_o  (cnt)
    );

    assign mem_we    = busy && (cnt[CW-1:OFS_W] == '0) && mask[idx];
    assign mem_addr  = {page_q, idx};
    assign mem_wdata = rd_data;

    AST_PAGE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_FILL && !seq_start) |=> $stable(page_q)) else $error("page moved"); // R4
    AST_EMPTY_NO_PROG: assert property (@(posedge clk) disable iff (rst)
        (stop_here && mask == '0) |=> !busy) else $error("empty commit"); // R6
    AST_PARTIAL_NO_PROG: assert property (@(posedge clk) disable iff (rst)
        (stop_here && stop_mid_byte) |=> !busy) else $error("partial commit"); // R6
    AST_LOCK_NO_PROG: assert property (@(posedge clk) disable iff (rst)
        (stop_here && wp_pin && page_q[PAGE_W-1 -: 2] == 2'b11) |=> !busy) else $error("locked commit"); // R7
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mask)) else $error("buffer changed in cycle"); // R8

endmodule

// File: tb/tb_pgwr_commit.sv
`timescale 1ns/1ps
module tb_pgwr_commit;
    localparam int PROG = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seq_start = 1'b0;
    logic [12:0] addr_in = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_evt = 1'b0;
    logic        stop_mid_byte = 1'b0;
    logic        wp_pin = 1'b0;
    logic        busy, mem_we;
    logic [12:0] mem_addr;
    logic [7:0]  mem_wdata;

    typedef struct { logic [12:0] a; logic [7:0] d; } exp_t;
    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pgwr_commit #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst(rst), .seq_start(seq_start), .addr_in(addr_in),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt),
        .stop_mid_byte(stop_mid_byte), .wp_pin(wp_pin), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Monitor: pops expected array writes in order (R2, R5).
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_q.size() == 0) begin
                check(0, "R5", "unexpected write addr", int'(mem_addr), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(mem_addr == e.a, "R2", "write addr", int'(mem_addr), int'(e.a));
                check(mem_wdata == e.d, "R2", "write data", int'(mem_wdata), int'(e.d));
            end
        end
    end

    // Driver: one write sequence, expected writes pushed from the requirements.
    task automatic do_write(input logic [12:0] a, input int n, input int seed,
                            input bit wp, input bit mid, input string rq);
        logic [7:0] pg [32];
        bit         got [32];
        bit         prog;
        int         cnt;
        for (int k = 0; k < 32; k++) got[k] = 0;
        for (int i = 0; i < n; i++) begin
            int o;
            o = (int'(a[4:0]) + i) % 32;
            pg[o]  = 8'(seed + i * 13);
            got[o] = 1;
        end
        prog = (n > 0) && !mid && !(wp && a[12:11] == 2'b11);
        if (prog) begin
            for (int k = 0; k < 32; k++) begin
                if (got[k]) exp_q.push_back('{a: {a[12:5], 5'(k)}, d: pg[k]});
            end
        end
        @(negedge clk);
        seq_start = 1'b1; addr_in = a; wp_pin = wp;
        @(negedge clk);
        seq_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1; byte_data = 8'(seed + i * 13);
            @(negedge clk);
        end
        byte_vld = 1'b0;
        stop_evt = 1'b1; stop_mid_byte = mid;
        @(negedge clk);
        stop_evt = 1'b0; stop_mid_byte = 1'b0;
        cnt = 0;
        while (busy && cnt < 10 * PROG) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == (prog ? PROG : 0), rq, "busy cycles", cnt, prog ? PROG : 0);
        check(exp_q.size() == 0, rq, "writes missing", exp_q.size(), 0);
        exp_q.delete();
        wp_pin = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(mem_we == 1'b0, "R1", "mem_we after reset", mem_we, 0);
        // R1: stray stop with no open sequence does nothing
        stop_evt = 1'b1; @(negedge clk); stop_evt = 1'b0; @(negedge clk);
        check(busy == 1'b0, "R1", "stray stop busy", busy, 0);

        do_write(13'h0123, 3, 8'h11, 0, 0, "R2");
        do_write(13'h0A5E, 4, 8'h40, 0, 0, "R4");   // offsets 30,31,0,1
        do_write(13'h0300, 34, 8'h05, 0, 0, "R4");  // overwrite offsets 0,1
        do_write(13'h0047, 1, 8'hC3, 0, 0, "R5");
        do_write(13'h0200, 0, 8'h00, 0, 0, "R6");
        do_write(13'h0210, 2, 8'h77, 0, 1, "R6");
        do_write(13'h1810, 3, 8'h21, 1, 0, "R7");
        do_write(13'h1FFF, 2, 8'h31, 1, 0, "R7");
        do_write(13'h17F0, 3, 8'h41, 1, 0, "R7");
        do_write(13'h1FE0, 3, 8'h51, 0, 0, "R7");
        do_write(13'h0000, 32, 8'h01, 0, 0, "R3");

        // R8: traffic during busy is ignored
        exp_q.push_back('{a: 13'h0400, d: 8'hAA});
        exp_q.push_back('{a: 13'h0401, d: 8'hBB});
        @(negedge clk);
        seq_start = 1'b1; addr_in = 13'h0400;
        @(negedge clk); seq_start = 1'b0;
        byte_vld = 1'b1; byte_data = 8'hAA; @(negedge clk);
        byte_data = 8'hBB; @(negedge clk);
        byte_vld = 1'b0; stop_evt = 1'b1; @(negedge clk);
        stop_evt = 1'b0;
        cnt = 0;
        while (busy && cnt < 10 * PROG) begin
            cnt++;
            seq_start = (cnt == 3); addr_in = 13'h0800;
            byte_vld  = (cnt == 4); byte_data = 8'hEE;
            stop_evt  = (cnt == 5);
            @(negedge clk);
        end
        seq_start = 1'b0; byte_vld = 1'b0; stop_evt = 1'b0;
        check(cnt == PROG, "R8", "busy cycles with traffic", cnt, PROG);
        check(exp_q.size() == 0, "R8", "writes missing", exp_q.size(), 0);
        // R8: no sequence left open, so a byte and stop now commit nothing
        byte_vld = 1'b1; byte_data = 8'h99; @(negedge clk);
        byte_vld = 1'b0; stop_evt = 1'b1; @(negedge clk);
        stop_evt = 1'b0; @(negedge clk);
        check(busy == 1'b0, "R8", "no leftover sequence", busy, 0);
        repeat (3) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule